// File: doc/BRIEF.md
# Flash Program and Erase Cycle Sequencer

This block sits behind the serial command decoder of a flash microcontroller's in-circuit programming port. The decoder hands it one-cycle strobes: a data word has been loaded, begin an erase-then-write cycle, begin a write-only cycle, or arm a bulk erase of program or data storage. The sequencer then runs a timed operation on its own. It sends single-cycle erase, write and bulk-erase strobes, plus the captured address and word, to the memory model. It raises `busy` for the whole operation. No finishing command is needed.

The sequencer enforces the programming discipline. A begin needs a fresh load. A begin that arrives while an operation runs is dropped. An armed bulk erase replaces the next accepted begin. The block also applies code protection, which it reads from the live configuration word. Protected user program words read back as zero. Writes to user program memory and to data memory are refused. Bulk erase is refused. The ID and configuration locations stay readable and writable.

The controller has four states. `ST_IDLE` waits for commands. `ST_WERASE` times the word erase. `ST_WRITE` times the write. `ST_BULK` times a bulk erase. Each state moves on as follows:
- From `ST_IDLE`, an accepted begin moves to `ST_BULK` when a bulk erase is armed and allowed. Otherwise it moves to `ST_WERASE` for an erase-then-write begin, or to `ST_WRITE` for a write-only begin, when the write is allowed.
- `ST_WERASE` moves to `ST_WRITE` when its timer expires.
- `ST_WRITE` and `ST_BULK` return to `ST_IDLE` when their timers expire.

Top module: `pe_sequencer`

## Requirements
- R1: After reset, `busy` and all five strobes are low.
- R2: A begin (`go_erase_prog` or `go_prog_only`) is accepted only in `ST_IDLE` and only if `ld_stb` has pulsed since the last accepted begin. An accepted begin clears that condition, and any other begin has no effect. A load that arrives while `busy` is high counts.
- R3: When `go_erase_prog` is accepted in cycle k, `erase_stb` pulses in cycle k+ERASE_CYCLES and `write_stb` pulses in cycle k+ERASE_CYCLES+PROG_CYCLES. In those cycles, `op_addr` and `op_word` hold the address and the loaded word.
- R4: When `go_prog_only` is accepted in cycle k, `write_stb` pulses in cycle k+PROG_CYCLES, and no `erase_stb` is produced.
- R5: A begin that arrives while `busy` is high is ignored. It does not change `op_addr` or `op_word` and produces no extra strobe.
- R6: After `bulk_prog_arm`, the next accepted begin of either kind pulses `bulk_user_stb` BULK_CYCLES later. `bulk_cfg_stb` pulses with it only when address bit 13 was 1 and `space_data` was 0 at the begin. The memory then clears the ID and reserved words but keeps the configuration word at offset 7.
- R7: After `bulk_data_arm`, the next accepted begin pulses `bulk_data_stb` BULK_CYCLES later. An accepted begin disarms any armed bulk erase.
- R8: Code protection is on exactly when `cfg_word[13:4]` are all zero.
- R9: While protection is on, `rd_word` is zero for a program-space address with bit 13 = 0. For configuration-space addresses (bit 13 = 1) and for data space, `rd_word` equals `rd_raw`.
- R10: While protection is on, a begin aimed at user program memory or data memory is consumed without `busy` or strobes. A begin aimed at configuration space runs normally.
- R11: While protection is on, a begin with a bulk erase armed is consumed without `busy` or strobes, and it disarms the bulk erase.
- R12: For a data-space operation, `op_word` is the loaded word with bits 13:8 cleared, and `op_addr` keeps only bits 5:0.
- R13: `busy` is high from the cycle after acceptance through the cycle of the last strobe, and `op_addr` and `op_word` do not change while `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_stb | input | 1 | A data word was loaded |
| ld_word | input | 14 | Loaded data word |
| addr | input | 14 | Current address counter; bit 13 selects configuration space |
| space_data | input | 1 | 1 = data memory command, 0 = program memory |
| go_erase_prog | input | 1 | Begin erase-then-write strobe |
| go_prog_only | input | 1 | Begin write-only strobe |
| bulk_prog_arm | input | 1 | Arm bulk erase of program memory |
| bulk_data_arm | input | 1 | Arm bulk erase of data memory |
| cfg_word | input | 14 | Current configuration word contents |
| rd_raw | input | 14 | Raw read data from memory |
| rd_word | output | 14 | Read data after protection masking |
| busy | output | 1 | Operation in progress |
| erase_stb | output | 1 | Word erase pulse |
| write_stb | output | 1 | Word write pulse |
| bulk_user_stb | output | 1 | Bulk erase of user program memory |
| bulk_cfg_stb | output | 1 | Bulk erase of ID and reserved configuration words |
| bulk_data_stb | output | 1 | Bulk erase of data memory |
| op_addr | output | 14 | Captured target address |
| op_word | output | 14 | Captured word to write |
| op_space_data | output | 1 | Captured data-space flag |

## Verification
On every cycle, the embedded properties check four things. Strobes are mutually exclusive. A write never follows an erase in the same cycle. `op_addr` and `op_word` stay steady while `busy` stays high. An unloaded begin or a begin that arrives while `busy` is high leaves the sequencer unchanged. They also check that any write completed under protection targets configuration space, and that a configuration bulk erase comes only with a user bulk erase. The bench scenarios establish what no single-cycle property can: the exact cycle of each strobe relative to its begin, the kind of bulk erase chosen by the address region, the disarming of an armed bulk erase after it is consumed or refused, and the read masking across regions and protection settings.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WERASE = 2'd1,
        ST_WRITE  = 2'd2,
        ST_BULK   = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_PROG = 2'd1,
        BK_DATA = 2'd2
    } bulk_kind_t;

endpackage

// File: rtl/pe_cycle_timer.sv
module pe_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= len - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done = (cnt_q == '0);

    AST_TIMER_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && done) |=> done); // R3

endmodule

// File: rtl/pe_protect_gate.sv
module pe_protect_gate #(
    parameter int WORD_W = 14,
    parameter int CP_LSB = 4
) (
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              cfg_space,
    input  logic              space_data,
    input  logic [WORD_W-1:0] rd_raw,
    output logic              cp_on,
    output logic [WORD_W-1:0] rd_word,
    output logic              wr_allow,
    output logic              bulk_allow
);

    logic unused_cfg_low;
    logic user_prog;

    assign unused_cfg_low = ^cfg_word[CP_LSB-1:0];
    assign cp_on          = ~|cfg_word[WORD_W-1:CP_LSB];
    assign user_prog      = !space_data && !cfg_space;

    always_comb begin
        rd_word    = (cp_on && user_prog) ? '0 : rd_raw;
        wr_allow   = !cp_on || (!space_data && cfg_space);
        bulk_allow = !cp_on;
    end

    always_comb begin
        if (!cp_on) begin
            AST_UNPROT_READ_PASS: assert (rd_word == rd_raw); // R9
        end
    end

endmodule

// File: rtl/pe_op_latch.sv
module pe_op_latch #(
    parameter int WORD_W  = 14,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 8,
    parameter int DATA_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] word,
    input  logic              space_data,
    output logic [ADDR_W-1:0] op_addr,
    output logic [WORD_W-1:0] op_word,
    output logic              op_space
);

    logic [ADDR_W-1:0] addr_eff;
    logic [WORD_W-1:0] word_eff;

    generate
        if (DATA_AW < ADDR_W) begin : g_addr_trim
            assign addr_eff = space_data ? {{(ADDR_W-DATA_AW){1'b0}}, addr[DATA_AW-1:0]} : addr;
        end else begin : g_addr_full
            assign addr_eff = addr;
        end
        if (DATA_W < WORD_W) begin : g_word_trim
            assign word_eff = space_data ? {{(WORD_W-DATA_W){1'b0}}, word[DATA_W-1:0]} : word;
        end else begin : g_word_full
            assign word_eff = word;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr  <= '0;
            op_word  <= '0;
            op_space <= 1'b0;
        end else if (capture) begin
            op_addr  <= addr_eff;
            op_word  <= word_eff;
            op_space <= space_data;
        end
    end

endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
    import pe_seq_pkg::*;
#(
    parameter int WORD_W       = 14,
    parameter int ADDR_W       = 14,
    parameter int DATA_W       = 8,
    parameter int DATA_AW      = 6,
    parameter int CP_LSB       = 4,
    parameter int ERASE_CYCLES = 100000,
    parameter int PROG_CYCLES  = 400000,
    parameter int BULK_CYCLES  = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_stb,
    input  logic [WORD_W-1:0] ld_word,
    input  logic [ADDR_W-1:0] addr,
    input  logic              space_data,
    input  logic              go_erase_prog,
    input  logic              go_prog_only,
    input  logic              bulk_prog_arm,
    input  logic              bulk_data_arm,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic [WORD_W-1:0] rd_raw,
    output logic [WORD_W-1:0] rd_word,
    output logic              busy,
    output logic              erase_stb,
    output logic              write_stb,
    output logic              bulk_user_stb,
    output logic              bulk_cfg_stb,
    output logic              bulk_data_stb,
    output logic [ADDR_W-1:0] op_addr,
    output logic [WORD_W-1:0] op_word,
    output logic              op_space_data
);

    localparam int MAX_EP  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int MAX_LEN = (MAX_EP > BULK_CYCLES) ? MAX_EP : BULK_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam logic [CNT_W-1:0] LEN_ERASE = CNT_W'(ERASE_CYCLES);
    localparam logic [CNT_W-1:0] LEN_PROG  = CNT_W'(PROG_CYCLES);
    localparam logic [CNT_W-1:0] LEN_BULK  = CNT_W'(BULK_CYCLES);

    seq_state_t       state_q, state_d;
    bulk_kind_t       arm_q, op_kind_q;
    logic             loaded_q;
    logic             op_cfg_q;
    logic             op_cp_q;
    logic             go_any;
    logic             accept;
    logic             tmr_start;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_done;
    logic             cp_on;
    logic             wr_allow;
    logic             bulk_allow;

    pe_protect_gate #(
        .WORD_W (WORD_W),
        .CP_LSB (CP_LSB)
    ) u_gate (
        .cfg_word   (cfg_word),
        .cfg_space  (addr[ADDR_W-1]),
        .space_data (space_data),
        .rd_raw     (rd_raw),
        .cp_on      (cp_on),
        .rd_word    (rd_word),
        .wr_allow   (wr_allow),
        .bulk_allow (bulk_allow)
    );

    pe_op_latch #(
        .WORD_W  (WORD_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .DATA_AW (DATA_AW)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (accept),
        .addr       (addr),
        .word       (ld_word),
        .space_data (space_data),
        .op_addr    (op_addr),
        .op_word    (op_word),
        .op_space   (op_space_data)
    );

    pe_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (tmr_len),
        .done  (tmr_done)
    );

    assign go_any = go_erase_prog || go_prog_only;
    assign accept = (state_q == ST_IDLE) && go_any && loaded_q;

    // next-state and timer launch
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        tmr_len   = LEN_PROG;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (arm_q != BK_NONE) begin
                        if (bulk_allow) begin
                            state_d   = ST_BULK;
                            tmr_start = 1'b1;
                            tmr_len   = LEN_BULK;
                        end
                    end else if (wr_allow) begin
                        tmr_start = 1'b1;
                        if (go_erase_prog) begin
                            state_d = ST_WERASE;
                            tmr_len = LEN_ERASE;
                        end else begin
                            state_d = ST_WRITE;
                            tmr_len = LEN_PROG;
                        end
                    end
                end
            end
            ST_WERASE: begin
                if (tmr_done) begin
                    state_d   = ST_WRITE;
                    tmr_start = 1'b1;
                    tmr_len   = LEN_PROG;
                end
            end
            ST_WRITE: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_BULK: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // command bookkeeping: load flag, bulk arm, per-operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q  <= 1'b0;
            arm_q     <= BK_NONE;
            op_kind_q <= BK_NONE;
            op_cfg_q  <= 1'b0;
            op_cp_q   <= 1'b0;
        end else begin
            if (ld_stb) begin
                loaded_q <= 1'b1;
            end else if (accept) begin
                loaded_q <= 1'b0;
            end
            if (bulk_prog_arm) begin
                arm_q <= BK_PROG;
            end else if (bulk_data_arm) begin
                arm_q <= BK_DATA;
            end else if (accept) begin
                arm_q <= BK_NONE;
            end
            if (accept) begin
                op_kind_q <= arm_q;
                op_cfg_q  <= addr[ADDR_W-1] && !space_data;
                op_cp_q   <= cp_on;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        erase_stb     = (state_q == ST_WERASE) && tmr_done;
        write_stb     = (state_q == ST_WRITE) && tmr_done;
        bulk_user_stb = (state_q == ST_BULK) && tmr_done && (op_kind_q == BK_PROG);
        bulk_cfg_stb  = bulk_user_stb && op_cfg_q;
        bulk_data_stb = (state_q == ST_BULK) && tmr_done && (op_kind_q == BK_DATA);
    end

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_stb, write_stb, bulk_user_stb, bulk_data_stb})); // R3
    AST_ERASE_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |=> (busy && !write_stb)); // R3
    AST_BEGIN_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go_any && !loaded_q) |=> !busy); // R2
    AST_BUSY_DROPS_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !write_stb && !bulk_user_stb && !bulk_data_stb && go_any) |=> $stable(op_addr)); // R5
    AST_CP_WRITE_CFG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (write_stb && op_cp_q) |-> (!op_space_data && op_addr[ADDR_W-1])); // R10
    AST_BULK_CFG_WITH_USER: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_cfg_stb |-> bulk_user_stb); // R6
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(op_addr) && $stable(op_word))); // R13

endmodule

// File: tb/sim_pe_sequencer.sv
module sim_pe_sequencer;

    localparam int LE = 5;
    localparam int LP = 7;
    localparam int LB = 9;

    localparam int K_ERASE = 0;
    localparam int K_WRITE = 1;
    localparam int K_BULKU = 2;
    localparam int K_BULKC = 3;
    localparam int K_BULKD = 4;

    localparam int M_NONE  = 0;
    localparam int M_WORD  = 1;
    localparam int M_BULKP = 2;
    localparam int M_BULKD = 3;

    typedef struct {
        int          kind;
        logic [13:0] a;
        logic [13:0] w;
        int          cyc;
        string       tag;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_stb = 1'b0;
    logic [13:0] ld_word = '0;
    logic [13:0] addr = '0;
    logic        space_data = 1'b0;
    logic        go_erase_prog = 1'b0;
    logic        go_prog_only = 1'b0;
    logic        bulk_prog_arm = 1'b0;
    logic        bulk_data_arm = 1'b0;
    logic [13:0] cfg_word = 14'h3FFF;
    logic [13:0] rd_raw = '0;
    logic [13:0] rd_word;
    logic        busy;
    logic        erase_stb;
    logic        write_stb;
    logic        bulk_user_stb;
    logic        bulk_cfg_stb;
    logic        bulk_data_stb;
    logic [13:0] op_addr;
    logic [13:0] op_word;
    logic        op_space_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;
    exp_item_t exp_q[$];

    pe_sequencer #(
        .ERASE_CYCLES (LE),
        .PROG_CYCLES  (LP),
        .BULK_CYCLES  (LB)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_stb        (ld_stb),
        .ld_word       (ld_word),
        .addr          (addr),
        .space_data    (space_data),
        .go_erase_prog (go_erase_prog),
        .go_prog_only  (go_prog_only),
        .bulk_prog_arm (bulk_prog_arm),
        .bulk_data_arm (bulk_data_arm),
        .cfg_word      (cfg_word),
        .rd_raw        (rd_raw),
        .rd_word       (rd_word),
        .busy          (busy),
        .erase_stb     (erase_stb),
        .write_stb     (write_stb),
        .bulk_user_stb (bulk_user_stb),
        .bulk_cfg_stb  (bulk_cfg_stb),
        .bulk_data_stb (bulk_data_stb),
        .op_addr       (op_addr),
        .op_word       (op_word),
        .op_space_data (op_space_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n && (erase_stb || write_stb || bulk_user_stb || bulk_data_stb || bulk_cfg_stb)) begin
            int k;
            exp_item_t it;
            if (erase_stb)                           k = K_ERASE;
            else if (write_stb)                      k = K_WRITE;
            else if (bulk_user_stb && bulk_cfg_stb)  k = K_BULKC;
            else if (bulk_user_stb)                  k = K_BULKU;
            else if (bulk_data_stb)                  k = K_BULKD;
            else                                     k = 99;
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R2/R5/R10/R11 unexpected strobe: actual kind %0d expected none", k);
            end else begin
                it = exp_q.pop_front();
                chk({it.tag, " kind"}, k, it.kind);
                chk({it.tag, " cycle"}, cyc, it.cyc);
                chk({it.tag, " op_addr"}, {18'd0, op_addr}, {18'd0, it.a});
                if (k == K_ERASE || k == K_WRITE) begin
                    chk({it.tag, " op_word"}, {18'd0, op_word}, {18'd0, it.w});
                end
            end
        end
    end

    task automatic push(int kind, logic [13:0] a, logic [13:0] w, int c, string tag);
        exp_item_t it;
        it.kind = kind; it.a = a; it.w = w; it.cyc = c; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic do_load(logic [13:0] w);
        @(negedge clk);
        ld_stb = 1'b1; ld_word = w;
        @(negedge clk);
        ld_stb = 1'b0;
    endtask

    task automatic do_arm(bit data_mem);
        @(negedge clk);
        if (data_mem) bulk_data_arm = 1'b1; else bulk_prog_arm = 1'b1;
        @(negedge clk);
        bulk_data_arm = 1'b0; bulk_prog_arm = 1'b0;
    endtask

    // drive a begin; expectations follow R3, R4, R6, R7 and R12
    task automatic do_begin(bit ep, logic [13:0] a, bit sp, logic [13:0] w,
                            int mode, bit busy_exp, string tag);
        int k;
        logic [13:0] ea;
        logic [13:0] ew;
        ea = sp ? {8'd0, a[5:0]} : a;
        ew = sp ? {6'd0, w[7:0]} : w;
        @(negedge clk);
        addr = a; space_data = sp;
        if (ep) go_erase_prog = 1'b1; else go_prog_only = 1'b1;
        k = cyc;
        if (mode == M_WORD) begin
            if (ep) begin
                push(K_ERASE, ea, ew, k + LE, tag);
                push(K_WRITE, ea, ew, k + LE + LP, tag);
            end else begin
                push(K_WRITE, ea, ew, k + LP, tag);
            end
        end else if (mode == M_BULKP) begin
            push((a[13] && !sp) ? K_BULKC : K_BULKU, ea, ew, k + LB, tag);
        end else if (mode == M_BULKD) begin
            push(K_BULKD, ea, ew, k + LB, tag);
        end
        @(negedge clk);
        go_erase_prog = 1'b0; go_prog_only = 1'b0;
        chk({tag, " busy after begin"}, {31'd0, busy}, {31'd0, busy_exp});
    endtask

    task automatic wait_done(string tag);
        for (int i = 0; i < 200; i++) begin
            if (exp_q.size() == 0 && !busy) break;
            @(negedge clk);
        end
        chk({tag, " idle with no pending strobe"}, {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_check(logic [13:0] cw, logic [13:0] a, bit sp, logic [13:0] raw,
                            logic [13:0] exp, string tag);
        @(negedge clk);
        cfg_word = cw; addr = a; space_data = sp; rd_raw = raw;
        #2;
        chk(tag, {18'd0, rd_word}, {18'd0, exp});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 strobes", {27'd0, erase_stb, write_stb, bulk_user_stb, bulk_cfg_stb, bulk_data_stb}, 32'd0);

        // R2 begin without any load
        do_begin(1'b1, 14'h0010, 1'b0, 14'h0, M_NONE, 1'b0, "R2 no load");
        repeat (12) @(negedge clk);

        // R3 erase then write
        do_load(14'h2AAA);
        do_begin(1'b1, 14'h0123, 1'b0, 14'h2AAA, M_WORD, 1'b1, "R3 erase+write");
        addr = 14'h0777;
        repeat (3) @(negedge clk);
        chk("R13 op_addr held", {18'd0, op_addr}, 32'h0123);
        chk("R13 busy mid-op", {31'd0, busy}, 32'd1);
        wait_done("R3");

        // R2 second begin without a fresh load
        do_begin(1'b0, 14'h0124, 1'b0, 14'h0, M_NONE, 1'b0, "R2 stale load");
        repeat (10) @(negedge clk);

        // R4 write-only
        do_load(14'h1555);
        do_begin(1'b0, 14'h0040, 1'b0, 14'h1555, M_WORD, 1'b1, "R4 write-only");
        wait_done("R4");

        // R5 begin while busy is dropped; load while busy counts for R2
        do_load(14'h0F0F);
        do_begin(1'b0, 14'h0100, 1'b0, 14'h0F0F, M_WORD, 1'b1, "R5 first op");
        do_load(14'h1111);
        do_begin(1'b1, 14'h0200, 1'b0, 14'h1111, M_NONE, 1'b1, "R5 begin while busy");
        chk("R5 op_addr unchanged", {18'd0, op_addr}, 32'h0100);
        chk("R5 op_word unchanged", {18'd0, op_word}, 32'h0F0F);
        wait_done("R5");
        do_begin(1'b0, 14'h0300, 1'b0, 14'h1111, M_WORD, 1'b1, "R2 load during busy");
        wait_done("R2");

        // R12 data space write
        do_load(14'h3C5A);
        do_begin(1'b0, 14'h0047, 1'b1, 14'h3C5A, M_WORD, 1'b1, "R12 data write");
        chk("R12 op_space_data", {31'd0, op_space_data}, 32'd1);
        wait_done("R12");

        // R6 bulk program erase, user region only
        do_arm(1'b0);
        do_load(14'h3FFF);
        do_begin(1'b0, 14'h0010, 1'b0, 14'h3FFF, M_BULKP, 1'b1, "R6 bulk user");
        wait_done("R6a");
        // R6 bulk program erase from configuration space
        do_arm(1'b0);
        do_load(14'h3FFF);
        do_begin(1'b1, 14'h2003, 1'b0, 14'h3FFF, M_BULKP, 1'b1, "R6 bulk user+cfg");
        wait_done("R6b");
        // R7 bulk data erase
        do_arm(1'b1);
        do_load(14'h3FFF);
        do_begin(1'b0, 14'h0055, 1'b1, 14'h3FFF, M_BULKD, 1'b1, "R7 bulk data");
        wait_done("R7");
        // R7 arm consumed: next begin is a plain write
        do_load(14'h0246);
        do_begin(1'b0, 14'h0066, 1'b0, 14'h0246, M_WORD, 1'b1, "R7 disarmed");
        wait_done("R7b");

        // R8 and R9 read masking
        rd_check(14'h0010, 14'h0005, 1'b0, 14'h1234, 14'h1234, "R8 cp bit4 set, unprotected");
        rd_check(14'h2000, 14'h0005, 1'b0, 14'h1234, 14'h1234, "R8 cp bit13 set, unprotected");
        rd_check(14'h000F, 14'h0005, 1'b0, 14'h1234, 14'h0000, "R9 protected user read");
        rd_check(14'h000F, 14'h2002, 1'b0, 14'h1234, 14'h1234, "R9 protected ID read");
        rd_check(14'h000F, 14'h0005, 1'b1, 14'h1234, 14'h1234, "R9 protected data read");

        // R10 protected writes
        do_load(14'h0ABC);
        do_begin(1'b1, 14'h0005, 1'b0, 14'h0ABC, M_NONE, 1'b0, "R10 user write blocked");
        repeat (14) @(negedge clk);
        do_begin(1'b0, 14'h0005, 1'b0, 14'h0ABC, M_NONE, 1'b0, "R10 blocked begin consumed load");
        repeat (10) @(negedge clk);
        do_load(14'h00AB);
        do_begin(1'b0, 14'h0005, 1'b1, 14'h00AB, M_NONE, 1'b0, "R10 data write blocked");
        repeat (10) @(negedge clk);
        do_load(14'h3FF5);
        do_begin(1'b1, 14'h2007, 1'b0, 14'h3FF5, M_WORD, 1'b1, "R10 cfg write allowed");
        wait_done("R10");

        // R11 bulk refused under protection, and disarmed
        do_arm(1'b0);
        do_load(14'h3FFF);
        do_begin(1'b0, 14'h2000, 1'b0, 14'h3FFF, M_NONE, 1'b0, "R11 bulk refused");
        repeat (12) @(negedge clk);
        cfg_word = 14'h3FFF;
        do_load(14'h0777);
        do_begin(1'b0, 14'h0020, 1'b0, 14'h0777, M_WORD, 1'b1, "R11 arm cleared");
        wait_done("R11");

        chk("R2 scoreboard drained", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule